// File: doc/BRIEF.md
# Power-Management Event, Control and Timer Register Block

This block holds the power-management event status, event enable and control registers of a system controller, together with a free-running power-management timer. Software reaches it through a simple 32-bit register bus that decodes a 64-byte window as sixteen dword slots. Hardware event sources feed it a timer tick, a power-button pulse, an APM command strobe and an external general-purpose event request. The block raises a level-sensitive system control interrupt (SCI). It also emits one-cycle shutdown and suspend request pulses when software arms a sleep transition.

The timer keeps a count that is wider than the visible field. Timer status is a comparison between that wide count and a stored overflow point. The overflow point only moves when software acknowledges the status, and the wide count keeps a wrap of the visible field from raising a false status. The window base-address decode, any SMBus logic and PCI configuration space lie outside the block.

Top module: `pwr_evt_timer`

## Requirements
- R1: `bus_addr` selects a dword slot. Slot 0 reads {enable[15:0], status[15:0]}, slot 1 reads {16'h0, control[15:0]}, slot 2 reads the timer zero-extended to 32 bits, and every other slot reads zero. Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled high.
- R2: The timer count advances by one on each clock with `tick` high. A read of the timer returns only the low TMR_W bits of the count (24 by default), so the value read wraps to 0.
- R3: Writing 1 to status bit 0 (timer status) while that bit is set moves the overflow point to (count + 2^(TMR_W-1)) rounded down to a multiple of 2^(TMR_W-1). The status then reads 0.
- R4: Status bit 0 reads 1 exactly when the wide internal count is at or past the overflow point. A wrap of the visible field raises no false status.
- R5: Status bits are write-1-to-clear: a written 1 clears the bit and a written 0 leaves it. Each write affects only the byte lanes whose `bus_be` bit is set (be[0] status/control bits 7:0, be[1] bits 15:8, be[2] enable bits 7:0, be[3] enable bits 15:8).
- R6: `sci` is high while any of status bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC) is set together with the same enable bit, or while `gpe_req` is high.
- R7: Control bit 13 (sleep enable) is never stored. When it is written as 1 in an enabled lane, the sleep-type field in bits 12:10 is decoded. Type 0 gives a one-cycle `shutdown_req` pulse in the cycle after the write.
- R8: Sleep type 1 sets status bits 15 (wake) and 8 (power button) and gives a one-cycle `suspend_req` pulse. Other types, or a write with bit 13 clear, produce no pulse. In all cases bits 12:10 are stored as written.
- R9: An APM strobe carrying 8'hF1 sets control bit 0 (SCI enable), 8'hF0 clears it, and any other value leaves it unchanged.
- R10: A `pwrbtn_evt` pulse sets status bit 8 only when enable bit 8 is set.
- R11: After reset all status, enable and control bits read 0, the timer reads 0, all outputs are low, and the first overflow point is 2^(TMR_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Dword slot within the 64-byte window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick | input | 1 | Timer advance enable |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| apm_valid | input | 1 | APM command strobe |
| apm_cmd | input | 8 | APM command value |
| gpe_req | input | 1 | External general-purpose event request |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | One-cycle soft-off request |
| suspend_req | output | 1 | One-cycle suspend request |

## Verification
The bench uses an 8-bit visible timer and steps the count across two overflow points and a wrap of the visible field. Its model of the overflow point is arithmetic, so a design that compares only the visible bits would raise status at the wrap, and a design that re-arms from the wrong base would miss the next point by a full period. Writes that use partial byte lanes probe the write-1-to-clear rule: a design that ignores the lane enables would clear or overwrite bits it should leave alone. The bench also checks that a sleep-enable write stores nothing, and that a type other than 0 or 1 produces no pulse.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

    localparam logic [3:0] SLOT_EVT  = 4'd0;
    localparam logic [3:0] SLOT_CTL  = 4'd1;
    localparam logic [3:0] SLOT_TMR  = 4'd2;

    localparam int unsigned ST_TMR    = 0;
    localparam int unsigned ST_GLOCK  = 5;
    localparam int unsigned ST_PWRBTN = 8;
    localparam int unsigned ST_RTC    = 10;
    localparam int unsigned ST_WAKE   = 15;

    localparam int unsigned CT_SCI_ON = 0;
    localparam int unsigned CT_SLP_GO = 13;
    localparam int unsigned CT_TYP_LO = 10;

    localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

    localparam logic [7:0] APM_SCI_ON  = 8'hF1;
    localparam logic [7:0] APM_SCI_OFF = 8'hF0;

    localparam logic [2:0] SLP_OFF  = 3'd0;
    localparam logic [2:0] SLP_SUSP = 3'd1;

endpackage

// File: rtl/pwr_evt_timer_core.sv
module pwr_evt_timer_core #(
    parameter int unsigned TMR_W   = 24,
    parameter int unsigned GUARD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rearm,
    output logic [TMR_W-1:0] count,
    output logic             tmr_sts
);
    localparam int unsigned CNT_W = TMR_W + GUARD_W;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] HALF = ONE << (TMR_W - 1);
    localparam logic [CNT_W-1:0] LOW_MASK = HALF - ONE;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ovf;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + ONE;
        end
        if (rearm) begin
            st_d.ovf = (st_q.cnt + HALF) & ~LOW_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.ovf <= HALF;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt[TMR_W-1:0];
    assign tmr_sts = (st_q.cnt >= st_q.ovf);

    // R2: visible count steps by one per tick and holds otherwise
    a_r2_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == TMR_W'($past(count) + 1'b1)));
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // R3: an acknowledged status without a coincident tick reads clear next
    a_r3_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !tick) |=> !tmr_sts);

endmodule

// File: rtl/pwr_evt_regs.sv
module pwr_evt_regs
    import pwr_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_evt,
    input  logic        wr_ctl,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        tmr_sts,
    input  logic        pwrbtn_evt,
    input  logic        apm_valid,
    input  logic [7:0]  apm_cmd,
    output logic [15:0] sts,
    output logic [15:0] en,
    output logic [15:0] ctl,
    output logic        rearm,
    output logic        shutdown_req,
    output logic        suspend_req
);
    typedef struct packed {
        logic        pwrbtn;
        logic        wake;
        logic [15:0] en;
        logic [15:0] ctl;
        logic        shut;
        logic        susp;
    } ev_state_t;

    ev_state_t st_d, st_q;

    logic [15:0] lo_mask, hi_mask, sts_clr, ctl_keep;
    logic [2:0]  slp_typ;
    logic        slp_go;

    always_comb begin
        lo_mask  = {{8{be[1]}}, {8{be[0]}}};
        hi_mask  = {{8{be[3]}}, {8{be[2]}}};
        sts_clr  = wr_evt ? (wdata[15:0] & lo_mask) : 16'h0000;
        ctl_keep = ~(16'h0001 << CT_SLP_GO);
        slp_typ  = wdata[CT_TYP_LO +: 3];
        slp_go   = wr_ctl && be[1] && wdata[CT_SLP_GO];
        rearm    = sts_clr[ST_TMR] && tmr_sts;

        st_d      = st_q;
        st_d.shut = 1'b0;
        st_d.susp = 1'b0;

        if (sts_clr[ST_PWRBTN]) st_d.pwrbtn = 1'b0;
        if (sts_clr[ST_WAKE])   st_d.wake   = 1'b0;

        if (wr_evt) begin
            st_d.en = (st_q.en & ~hi_mask) | (wdata[31:16] & hi_mask);
        end

        if (wr_ctl) begin
            st_d.ctl = (st_q.ctl & ~lo_mask) | (wdata[15:0] & lo_mask & ctl_keep);
        end

        if (slp_go) begin
            case (slp_typ)
                SLP_OFF: st_d.shut = 1'b1;
                SLP_SUSP: begin
                    st_d.susp   = 1'b1;
                    st_d.wake   = 1'b1;
                    st_d.pwrbtn = 1'b1;
                end
                default: ;
            endcase
        end

        if (apm_valid) begin
            if (apm_cmd == APM_SCI_ON)  st_d.ctl[CT_SCI_ON] = 1'b1;
            if (apm_cmd == APM_SCI_OFF) st_d.ctl[CT_SCI_ON] = 1'b0;
        end

        if (pwrbtn_evt && st_q.en[ST_PWRBTN]) begin
            st_d.pwrbtn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts          = {st_q.wake, 6'b000000, st_q.pwrbtn, 7'b0000000, tmr_sts};
    assign en           = st_q.en;
    assign ctl          = st_q.ctl;
    assign shutdown_req = st_q.shut;
    assign suspend_req  = st_q.susp;

    // R10: an enabled power-button event is visible in status next cycle
    a_r10_pwrbtn_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_evt && en[ST_PWRBTN]) |=> sts[ST_PWRBTN]);
    // R9: APM commands drive the SCI-enable bit
    a_r9_apm_on: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_valid && apm_cmd == APM_SCI_ON) |=> ctl[CT_SCI_ON]);
    a_r9_apm_off: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_valid && apm_cmd == APM_SCI_OFF) |=> !ctl[CT_SCI_ON]);
    // R7: a shutdown pulse always follows a type-0 sleep-enable write
    a_r7_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_ctl && be[1] && wdata[CT_SLP_GO] &&
                               wdata[CT_TYP_LO +: 3] == SLP_OFF));
    // R8: shutdown and suspend never coincide; suspend leaves wake status set
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && suspend_req));
    a_r8_wake_on_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> sts[ST_WAKE]);

endmodule

// File: rtl/pwr_evt_timer.sv
module pwr_evt_timer
    import pwr_evt_pkg::*;
#(
    parameter int unsigned TMR_W   = 24,
    parameter int unsigned GUARD_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick,
    input  logic        pwrbtn_evt,
    input  logic        apm_valid,
    input  logic [7:0]  apm_cmd,
    input  logic        gpe_req,
    output logic        sci,
    output logic        shutdown_req,
    output logic        suspend_req
);
    logic [TMR_W-1:0] tmr_count;
    logic             tmr_sts;
    logic             rearm;
    logic [15:0]      sts, en, ctl;
    logic             wr_evt, wr_ctl;

    assign wr_evt = bus_wr && (bus_addr == SLOT_EVT);
    assign wr_ctl = bus_wr && (bus_addr == SLOT_CTL);

    pwr_evt_timer_core #(.TMR_W(TMR_W), .GUARD_W(GUARD_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rearm   (rearm),
        .count   (tmr_count),
        .tmr_sts (tmr_sts)
    );

    pwr_evt_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_evt       (wr_evt),
        .wr_ctl       (wr_ctl),
        .be           (bus_be),
        .wdata        (bus_wdata),
        .tmr_sts      (tmr_sts),
        .pwrbtn_evt   (pwrbtn_evt),
        .apm_valid    (apm_valid),
        .apm_cmd      (apm_cmd),
        .sts          (sts),
        .en           (en),
        .ctl          (ctl),
        .rearm        (rearm),
        .shutdown_req (shutdown_req),
        .suspend_req  (suspend_req)
    );

    logic [31:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            case (bus_addr)
                SLOT_EVT: rdata_d = {en, sts};
                SLOT_CTL: rdata_d = {16'h0000, ctl};
                SLOT_TMR: rdata_d = 32'(tmr_count);
                default:  rdata_d = 32'h0000_0000;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
    assign sci = (|(sts & en & SCI_SRC_MASK)) || gpe_req;

    // R6: an external request always reaches the interrupt
    a_r6_gpe_reaches_sci: assert property (@(posedge clk) disable iff (!rst_n)
        gpe_req |-> sci);
    // R1: a read of an unmapped slot returns zero
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > SLOT_TMR) |=> (bus_rdata == 32'h0));

endmodule

// File: tb/pwr_evt_timer_test.sv
module pwr_evt_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;
    localparam int HALF = 1 << (TW - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        apm_valid = 1'b0;
    logic [7:0]  apm_cmd = '0;
    logic        gpe_req = 1'b0;
    logic        sci, shutdown_req, suspend_req;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    int ovf = HALF;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_evt_timer #(.TMR_W(TW), .GUARD_W(8)) uut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_be (bus_be), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .tick (tick), .pwrbtn_evt (pwrbtn_evt),
        .apm_valid (apm_valid), .apm_cmd (apm_cmd), .gpe_req (gpe_req),
        .sci (sci), .shutdown_req (shutdown_req), .suspend_req (suspend_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        cnt += n;
    endtask

    // software acknowledge of the timer status, with the bench's own re-arm model
    task automatic ack_timer();
        if (cnt >= ovf) ovf = ((cnt + HALF) / HALF) * HALF;
        wr(4'd0, 4'b0001, 32'h0000_0001);
    endtask

    task automatic apm(input logic [7:0] c);
        @(negedge clk);
        apm_cmd = c; apm_valid = 1'b1;
        @(negedge clk);
        apm_valid = 1'b0;
    endtask

    task automatic tmr_status(input string req);
        logic [31:0] v;
        rd(4'd0, v);
        chk(req, {31'b0, v[0]}, {31'b0, (cnt >= ovf)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(4'd0, v); chk("R11 event slot", v, 32'h0);
        rd(4'd1, v); chk("R11 control", v, 32'h0);
        rd(4'd2, v); chk("R11 timer", v, 32'h0);
        chk("R11 outputs", {29'b0, sci, shutdown_req, suspend_req}, 32'h0);

        // R1 unmapped slots
        for (int a = 3; a < 16; a++) begin
            rd(4'(a), v); chk("R1 unmapped slot", v, 32'h0);
        end

        // R2 / R4 timer counting up to the first overflow point
        ticks(100);
        rd(4'd2, v); chk("R2 timer value", v, 32'(cnt % (1 << TW)));
        tmr_status("R4 below first point");
        ticks(27);
        tmr_status("R4 one short of point");
        ticks(1);
        tmr_status("R4 at first point");
        chk("R6 status without enable", {31'b0, sci}, 32'h0);
        wr(4'd0, 4'b1100, 32'h0001_0000);
        chk("R6 timer source", {31'b0, sci}, 32'h1);
        rd(4'd0, v); chk("R1 event slot layout", v, 32'h0001_0001);

        // R3 acknowledge and re-arm
        ack_timer();
        tmr_status("R3 cleared after ack");
        chk("R6 sci drops", {31'b0, sci}, 32'h0);
        ticks(HALF - 1);
        rd(4'd2, v); chk("R2 timer before wrap", v, 32'(cnt % (1 << TW)));
        tmr_status("R4 before wrap");
        ticks(1);
        rd(4'd2, v); chk("R2 timer wraps", v, 32'(cnt % (1 << TW)));
        tmr_status("R4 at second point");

        // R5 lane enables on the clear
        wr(4'd0, 4'b0010, 32'h0000_0001);
        tmr_status("R5 wrong lane keeps");
        wr(4'd0, 4'b0011, 32'h0000_0000);
        tmr_status("R5 zero keeps");
        ack_timer();
        tmr_status("R3 second ack");
        ticks(HALF - 1);
        tmr_status("R4 just before third point");
        ticks(1);
        tmr_status("R4 third point");
        ack_timer();
        wr(4'd0, 4'b1100, 32'h0000_0000);

        // R10 power button gating
        @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
        rd(4'd0, v); chk("R10 disabled button ignored", v, 32'h0);
        wr(4'd0, 4'b1100, 32'h0100_0000);
        @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
        rd(4'd0, v); chk("R10 enabled button sets", v, 32'h0100_0100);
        chk("R6 button source", {31'b0, sci}, 32'h1);
        wr(4'd0, 4'b0001, 32'h0000_0100);
        rd(4'd0, v); chk("R5 low lane cannot clear bit 8", v, 32'h0100_0100);
        wr(4'd0, 4'b0011, 32'h0000_FEFF);
        rd(4'd0, v); chk("R5 zero bit keeps", v, 32'h0100_0100);
        wr(4'd0, 4'b0010, 32'h0000_0100);
        rd(4'd0, v); chk("R5 one clears", v, 32'h0100_0000);
        chk("R6 sci low", {31'b0, sci}, 32'h0);

        // R6 external request
        @(negedge clk); gpe_req = 1'b1; #1;
        chk("R6 external request", {31'b0, sci}, 32'h1);
        @(negedge clk); gpe_req = 1'b0; #1;
        chk("R6 external released", {31'b0, sci}, 32'h0);

        // R8 suspend
        wr(4'd1, 4'b0011, 32'h0000_2400);
        chk("R8 suspend pulse", {30'b0, shutdown_req, suspend_req}, 32'h1);
        @(negedge clk);
        chk("R8 suspend one cycle", {30'b0, shutdown_req, suspend_req}, 32'h0);
        rd(4'd1, v); chk("R7 sleep enable not stored", v, 32'h0000_0400);
        rd(4'd0, v); chk("R8 wake and button set", v, 32'h0100_8100);
        wr(4'd0, 4'b0011, 32'h0000_8100);
        rd(4'd0, v); chk("R5 clear both", v, 32'h0100_0000);

        // R7 shutdown
        wr(4'd1, 4'b0011, 32'h0000_2000);
        chk("R7 shutdown pulse", {30'b0, shutdown_req, suspend_req}, 32'h2);
        @(negedge clk);
        chk("R7 shutdown one cycle", {30'b0, shutdown_req, suspend_req}, 32'h0);
        rd(4'd1, v); chk("R7 control after shutdown", v, 32'h0);

        // R8 other types and no enable
        wr(4'd1, 4'b0011, 32'h0000_2800);
        chk("R8 type 2 no pulse", {30'b0, shutdown_req, suspend_req}, 32'h0);
        rd(4'd1, v); chk("R8 type stored", v, 32'h0000_0800);
        wr(4'd1, 4'b0001, 32'h0000_2000);
        chk("R7 low lane no pulse", {30'b0, shutdown_req, suspend_req}, 32'h0);
        rd(4'd1, v); chk("R5 high lane kept", v, 32'h0000_0800);
        wr(4'd1, 4'b0011, 32'h0000_0400);
        chk("R8 no enable no pulse", {30'b0, shutdown_req, suspend_req}, 32'h0);
        rd(4'd0, v); chk("R8 status untouched", v, 32'h0100_0000);

        // R9 APM
        apm(8'hF1); rd(4'd1, v); chk("R9 APM on", v, 32'h0000_0401);
        apm(8'h55); rd(4'd1, v); chk("R9 other value", v, 32'h0000_0401);
        apm(8'hF0); rd(4'd1, v); chk("R9 APM off", v, 32'h0000_0400);

        // R5 enable register lanes
        wr(4'd0, 4'b1100, 32'hA5C3_0000);
        rd(4'd0, v); chk("R5 enable full write", v[31:16], 32'h0000_A5C3);
        wr(4'd0, 4'b0100, 32'h00FF_0000);
        rd(4'd0, v); chk("R5 enable low lane", v[31:16], 32'h0000_A5FF);
        rd(4'd2, v); chk("R2 timer final", v, 32'(cnt % (1 << TW)));
        tmr_status("R4 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule